// File: doc/BRIEF.md
# Performance Monitor Counter Bank

This block holds six wrapping 32-bit event counters and two 64-bit control registers. Software reaches all of them through a single-cycle register port. Counters 1 to 4 are general purpose. Each one counts a hardware event strobe picked by its own select field in the event-select register. Counter 5 adds the number of instructions completed in each cycle, a value from 0 to 7. Counter 6 counts clock cycles.

The mode register holds two freeze bits. One halts counters 1 to 4 and the other halts counters 5 and 6, so each group can be stopped on its own. The mode register also holds two condition enables for the counter-negative condition, meaning bit 31 of a counter is set. The first enable covers counter 1 only and the second covers counters 2 to 6. A counter in a frozen group never contributes to the condition. The OR of all contributing counters is registered and driven out as a performance alert. Delivering that alert as an exception is left to the surrounding logic.

Top module: `perf_counter_bank`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register reads zero and perf_alert is 0.
- R2: Register address 0 is the mode register and address 1 is the event-select register. Each reads back exactly the 64-bit value last written. Addresses 2 to 7 are counters 1 to 6, read zero-extended; a write stores reg_wdata[31:0].
- R3: A register-port write to a counter takes effect in the same edge and replaces any increment of that counter in that cycle.
- R4: While mode bit 4 is 0, counter 6 increases by one at every clock edge.
- R5: While mode bit 4 is 0, counter 5 adds the value on inst_done at every clock edge.
- R6: While mode bit 5 is 1, counters 1 to 4 hold their values whatever the event strobes do.
- R7: While mode bit 4 is 1, counters 5 and 6 hold their values whatever inst_done is.
- R8: The select fields for counters 1, 2, 3 and 4 sit in event-select bits 31:24, 23:16, 15:8 and 7:0. With its group running, a counter increments by one in each cycle in which evt_strobe[select] is 1.
- R9: A select value of 8 or more never increments its counter.
- R10: All counters wrap from 0xFFFF_FFFF to 0.
- R11: perf_alert is 1 one cycle after counter 1 has bit 31 set while mode bit 15 is 1 and mode bit 5 is 0.
- R12: Mode bit 14 enables the negative condition for counters 2 to 6 and not for counter 1. Mode bit 15 does not enable it for counters 2 to 6.
- R13: A counter whose group is frozen (bit 5 for counters 1 to 4, bit 4 for counters 5 and 6) never raises perf_alert, even with its enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for reg_addr |
| inst_done | input | 3 | Instructions completed this cycle |
| evt_strobe | input | 8 | Event strobes for the general-purpose counters |
| perf_alert | output | 1 | Registered counter-negative alert |

## Verification
The bench uses the default parameters: 32-bit counters, eight event strobes and a three-bit completed-instruction count. At that size it can sweep every select value 0 to 9 against a stream of strobe patterns, and every inst_done value, and compute the expected totals by arithmetic. It also covers each freeze-bit and enable-bit combination that decides perf_alert, and the wrap at the 32-bit boundary.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    // Convert an MSB-0 position of a 64-bit register to an LSB-0 index
    function automatic int unsigned m0(input int unsigned n);
        return 63 - n;
    endfunction

    localparam int unsigned FRZ_GP_BIT  = m0(58); // counters 1..4 halt
    localparam int unsigned FRZ_FX_BIT  = m0(59); // counters 5..6 halt
    localparam int unsigned NEG_EN1_BIT = m0(48); // counter 1 negative enable
    localparam int unsigned NEG_ENJ_BIT = m0(49); // counters 2..6 negative enable
    localparam int unsigned SEL_TOP_BIT = m0(32); // top of counter 1 select

    localparam int unsigned ADR_MODE = 0;
    localparam int unsigned ADR_ESEL = 1;
    localparam int unsigned ADR_CNT0 = 2;
endpackage

// File: rtl/pcb_evtsel.sv
module pcb_evtsel #(
    parameter int SEL_W   = 8,
    parameter int NUM_EVT = 8
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_EVT-1:0] evt,
    output logic               hit
);
    always_comb begin
        hit = 1'b0;
        for (int e = 0; e < NUM_EVT; e++) begin
            if (sel == SEL_W'(e)) hit = evt[e];
        end
    end
endmodule

// File: rtl/pcb_counter.sv
module pcb_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         frozen,
    input  logic [W-1:0] step,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (wr_en)  cnt <= wr_val;
        else if (!frozen) cnt <= cnt + step;
    end
endmodule

// File: rtl/pcb_alert.sv
module pcb_alert #(
    parameter int NUM_CNT  = 6,
    parameter int NUM_PROG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] neg,
    input  logic               frz_gp,
    input  logic               frz_fx,
    input  logic               en_first,
    input  logic               en_rest,
    output logic               alert
);
    logic [NUM_CNT-1:0] live;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_gate
        localparam bit IS_GP = (i < NUM_PROG);
        logic en_i, run_i;
        assign en_i  = (i == 0) ? en_first : en_rest;
        assign run_i = IS_GP ? !frz_gp : !frz_fx;
        assign live[i] = neg[i] & en_i & run_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) alert <= 1'b0;
        else        alert <= |live;
    end
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NUM_PROG = 4,
    parameter int SEL_W    = 8,
    parameter int NUM_EVT  = 8,
    parameter int INST_W   = 3,
    parameter int REG_W    = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [INST_W-1:0]  inst_done,
    input  logic [NUM_EVT-1:0] evt_strobe,
    output logic               perf_alert
);
    localparam int NUM_CNT = NUM_PROG + 2;
    localparam int IDX_INS = NUM_PROG;
    localparam int IDX_CYC = NUM_PROG + 1;

    logic [REG_W-1:0] mode_q;
    logic [REG_W-1:0] esel_q;
    logic [CNT_W-1:0] cnt_q [NUM_CNT];
    logic [NUM_CNT-1:0] neg;
    logic frz_gp, frz_fx;

    assign frz_gp = mode_q[FRZ_GP_BIT];
    assign frz_fx = mode_q[FRZ_FX_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            esel_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == 3'(ADR_MODE)) mode_q <= reg_wdata;
            if (reg_addr == 3'(ADR_ESEL)) esel_q <= reg_wdata;
        end
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic [CNT_W-1:0] step;
        logic             frozen;
        logic             wr_hit;

        if (i < NUM_PROG) begin : g_prog
            logic hit;
            pcb_evtsel #(.SEL_W(SEL_W), .NUM_EVT(NUM_EVT)) u_sel (
                .sel (esel_q[SEL_TOP_BIT - i*SEL_W -: SEL_W]),
                .evt (evt_strobe),
                .hit (hit)
            );
            assign step   = CNT_W'(hit);
            assign frozen = frz_gp;
        end else if (i == IDX_INS) begin : g_ins
            assign step   = CNT_W'(inst_done);
            assign frozen = frz_fx;
        end else begin : g_cyc
            assign step   = CNT_W'(1);
            assign frozen = frz_fx;
        end

        assign wr_hit = reg_wr && (reg_addr == 3'(ADR_CNT0 + i));

        pcb_counter #(.W(CNT_W)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_hit),
            .wr_val (reg_wdata[CNT_W-1:0]),
            .frozen (frozen),
            .step   (step),
            .cnt    (cnt_q[i])
        );
        assign neg[i] = cnt_q[i][CNT_W-1];
    end

    pcb_alert #(.NUM_CNT(NUM_CNT), .NUM_PROG(NUM_PROG)) u_alert (
        .clk      (clk),
        .rst_n    (rst_n),
        .neg      (neg),
        .frz_gp   (frz_gp),
        .frz_fx   (frz_fx),
        .en_first (mode_q[NEG_EN1_BIT]),
        .en_rest  (mode_q[NEG_ENJ_BIT]),
        .alert    (perf_alert)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == 3'(ADR_MODE))      reg_rdata = mode_q;
        else if (reg_addr == 3'(ADR_ESEL)) reg_rdata = esel_q;
        else begin
            for (int k = 0; k < NUM_CNT; k++) begin
                if (reg_addr == 3'(ADR_CNT0 + k)) reg_rdata = REG_W'(cnt_q[k]);
            end
        end
    end
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
    parameter int CNT_W = 32,
    parameter int REG_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] mode_q,
    input logic [CNT_W-1:0] cnt_first,
    input logic [CNT_W-1:0] cnt_last,
    input logic             perf_alert
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> !perf_alert);

    assert_write_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd7) |=> cnt_last == $past(reg_wdata[CNT_W-1:0]));

    assert_cycle_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[4] && !(reg_wr && reg_addr == 3'd7)) |=> cnt_last == $past(cnt_last) + 1'b1);

    assert_gp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[5] && !(reg_wr && reg_addr == 3'd2)) |=> $stable(cnt_first));

    assert_fx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[4] && !(reg_wr && reg_addr == 3'd7)) |=> $stable(cnt_last));

    assert_frozen_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[5] && mode_q[4]) |=> !perf_alert);
endmodule

bind perf_counter_bank pcb_checker #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .mode_q     (mode_q),
    .cnt_first  (cnt_q[0]),
    .cnt_last   (cnt_q[5]),
    .perf_alert (perf_alert)
);

// File: tb/perf_counter_bank_tb.sv
module perf_counter_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [2:0]  inst_done = '0;
    logic [7:0]  evt_strobe = '0;
    logic        perf_alert;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [63:0] FA = 64'h20; // freeze counters 1..4
    localparam logic [63:0] FB = 64'h10; // freeze counters 5..6
    localparam logic [63:0] E1 = 64'h8000;
    localparam logic [63:0] EJ = 64'h4000;

    always #10 clk = ~clk;

    perf_counter_bank u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .inst_done(inst_done),
        .evt_strobe(evt_strobe), .perf_alert(perf_alert)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [63:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        int exp_sum;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset read", v, 64'd0);
        end
        check("R1 reset alert", {63'd0, perf_alert}, 64'd0);

        // R2 control readback (keep both groups frozen)
        wr(3'd1, 64'hA5C3_0F1E_5566_7788);
        rd(3'd1, v); check("R2 esel readback", v, 64'hA5C3_0F1E_5566_7788);
        wr(3'd0, 64'hF00D_0000_000C_0030);
        rd(3'd0, v); check("R2 mode readback", v, 64'hF00D_0000_000C_0030);
        wr(3'd2, 64'hFFFF_FFFF_1234_5678);
        rd(3'd2, v); check("R2 counter write low half", v, 64'h1234_5678);

        // R3 write priority and R4 cycle counting, counters 5..6 running
        wr(3'd0, FA);
        wr(3'd7, 64'h100);
        rd(3'd7, v); check("R3 write beats increment", v, 64'h100);
        repeat (10) @(negedge clk);
        rd(3'd7, v); check("R4 cycle count", v, 64'h10A);

        // R5 instruction accumulation sweep
        wr(3'd0, FA | FB);
        wr(3'd6, 64'd0);
        wr(3'd7, 64'd0);
        wr(3'd0, FA);
        exp_sum = 0;
        for (int i = 0; i < 64; i++) begin
            inst_done = 3'((i * 5) % 8);
            exp_sum += (i * 5) % 8;
            @(negedge clk);
        end
        inst_done = '0;
        wr(3'd0, FA | FB);
        rd(3'd6, v); check("R5 instruction sum", v, 64'(exp_sum));
        rd(3'd7, v); check("R4 cycles over sweep", v, 64'd65);

        // R7 group 5..6 frozen
        inst_done = 3'd7;
        repeat (10) @(negedge clk);
        inst_done = '0;
        rd(3'd6, v); check("R7 counter 5 held", v, 64'(exp_sum));
        rd(3'd7, v); check("R7 counter 6 held", v, 64'd65);

        // R8 / R9 select sweep on counter 1
        for (int s = 0; s < 10; s++) begin
            int exp_c;
            wr(3'd2, 64'd0);
            wr(3'd1, 64'(s) << 24);
            wr(3'd0, FB);
            exp_c = 0;
            for (int p = 0; p < 40; p++) begin
                logic [7:0] pat;
                pat = 8'((p * 37 + s * 11) ^ (p >> 1));
                evt_strobe = pat;
                if (s < 8 && pat[s]) exp_c++;
                @(negedge clk);
            end
            evt_strobe = '0;
            wr(3'd0, FA | FB);
            rd(3'd2, v);
            check(s < 8 ? "R8 counter 1 select" : "R9 out-of-range select", v, 64'(exp_c));
        end

        // R8 all four select fields at once
        wr(3'd2, 64'd0); wr(3'd3, 64'd0); wr(3'd4, 64'd0); wr(3'd5, 64'd0);
        wr(3'd1, 64'h0103_0709);
        wr(3'd0, FB);
        begin
            int e1, e2, e3;
            e1 = 0; e2 = 0; e3 = 0;
            for (int p = 0; p < 256; p++) begin
                evt_strobe = 8'(p);
                if (p[1]) e1++;
                if (p[3]) e2++;
                if (p[7]) e3++;
                @(negedge clk);
            end
            evt_strobe = '0;
            wr(3'd0, FA | FB);
            rd(3'd2, v); check("R8 field 31:24", v, 64'(e1));
            rd(3'd3, v); check("R8 field 23:16", v, 64'(e2));
            rd(3'd4, v); check("R8 field 15:8", v, 64'(e3));
            rd(3'd5, v); check("R9 field 7:0 value 9", v, 64'd0);
        end

        // R6 group 1..4 frozen while 5..6 run
        wr(3'd1, 64'd0);
        wr(3'd2, 64'd77);
        wr(3'd0, FA);
        evt_strobe = 8'hFF;
        repeat (10) @(negedge clk);
        evt_strobe = '0;
        rd(3'd2, v); check("R6 counter 1 held", v, 64'd77);

        // R10 wrap
        wr(3'd0, FA | FB);
        wr(3'd7, 64'hFFFF_FFFF);
        wr(3'd0, FA);
        rd(3'd7, v); check("R10 before wrap", v, 64'hFFFF_FFFF);
        @(negedge clk);
        rd(3'd7, v); check("R10 wrapped", v, 64'd0);

        // Alert section: clear fixed group, load negative counter 1
        wr(3'd0, FA | FB);
        wr(3'd6, 64'd0); wr(3'd7, 64'd0);
        wr(3'd3, 64'd0); wr(3'd4, 64'd0); wr(3'd5, 64'd0);
        wr(3'd2, 64'h8000_0000);
        wr(3'd0, FA | FB | E1 | EJ);
        @(negedge clk);
        check("R13 both frozen no alert", {63'd0, perf_alert}, 64'd0);
        wr(3'd0, FB | E1);
        @(negedge clk);
        check("R11 counter 1 alert", {63'd0, perf_alert}, 64'd1);
        wr(3'd0, FB | EJ);
        @(negedge clk);
        check("R12 bit 14 ignores counter 1", {63'd0, perf_alert}, 64'd0);
        wr(3'd0, FB);
        @(negedge clk);
        check("R11 alert drops with enable off", {63'd0, perf_alert}, 64'd0);
        wr(3'd2, 64'd0);
        wr(3'd3, 64'h8000_0000);
        wr(3'd0, FB | E1);
        @(negedge clk);
        check("R12 bit 15 ignores counter 2", {63'd0, perf_alert}, 64'd0);
        wr(3'd0, FB | EJ);
        @(negedge clk);
        check("R12 counter 2 alert", {63'd0, perf_alert}, 64'd1);
        wr(3'd0, FA | FB | EJ);
        @(negedge clk);
        check("R13 frozen counter 2 quiet", {63'd0, perf_alert}, 64'd0);
        wr(3'd3, 64'd0);
        wr(3'd6, 64'h8000_0000);
        @(negedge clk);
        check("R13 frozen counter 5 quiet", {63'd0, perf_alert}, 64'd0);
        wr(3'd0, FA | EJ);
        @(negedge clk);
        check("R12 counter 5 alert", {63'd0, perf_alert}, 64'd1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule